// File: doc/BRIEF.md
# Address-Masked GPIO Data Port

This block is an eight-line general purpose I/O peripheral on a 32-bit APB-style register bus. It holds a direction register and an output register. It drives the pad output enables and pad outputs from those registers. The pad inputs pass through a two-flop synchronizer. The synchronized vector is also exported, so that a separate interrupt unit can attach to it.

The data register sits in a 1 KB window at the bottom of a 4 KB region. Bus address bits [9:2] act as a per-pin mask. On a write they choose which output bits change. On a read they choose which bits are returned. Software can therefore set or clear a single pin with one bus write and no read-modify-write. The region also answers identification reads near its top. Every other offset reads as zero and ignores writes. Bus transfers finish in their access phase with no wait states.

Top module: `gpioMaskedPort`

## Requirements
- R1: After reset the direction register is 0, which makes every line an input. The output register is 0, and padOe and padOut are both 0.
- R2: A write at an offset in 0x000-0x3FC updates output bit n from pwdata[n] only where paddr[n+2] is 1. Every other output bit keeps its value. For example, offset 0x004 touches only pin 0.
- R3: A read at an offset in 0x000-0x3FC returns 0 in every bit n whose paddr[n+2] is 0. prdata[31:8] is always 0.
- R4: In an unmasked bit, a data read returns the output register bit when the line is an output (direction bit 1). It returns the synchronized pad value when the line is an input (direction bit 0).
- R5: A change on padIn appears on syncIn, and in data reads, after exactly two rising clock edges.
- R6: The direction register is written and read at offset 0x400, using bits [7:0]. padOe equals the direction register.
- R7: padOut always equals the output register. A data write updates the output register even when the line is configured as an input.
- R8: Identification reads return one byte each in prdata[7:0]. The values are 0x61 at offset 0xFE0, 0x10 at 0xFE4, 0x04 at 0xFE8 and 0x00 at 0xFEC, which together form the 20-bit value 0x41061.
- R9: An unmapped offset (for example 0x404 or 0x800) reads as 0. A write there leaves the direction and output registers unchanged.
- R10: A data write at offset 0x000 has an all-zero mask and changes no output bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| psel | input | 1 | Peripheral select |
| penable | input | 1 | Access phase marker |
| pwrite | input | 1 | 1 for write, 0 for read |
| paddr | input | 12 | Byte offset within the 4 KB region |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid while psel is high |
| padIn | input | 8 | Raw pad inputs |
| padOut | output | 8 | Pad output values |
| padOe | output | 8 | Pad output enables |
| syncIn | output | 8 | Synchronized pad inputs for an interrupt unit |

## Verification
Two functions can meet on the same line within a short window. One is a direction change. The other is a data read, whose source for each pin is either the output register or the synchronizer, depending on that pin's direction bit. The bench writes a new direction value and issues a masked data read in the very next transfer, while the pad inputs differ from the output register. The scoreboard's expected value takes each bit from the source chosen by the new direction. In a separate test, a pad change is timed against the clock, and syncIn is judged one edge and two edges later.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int NUM_PINS = 8;
  localparam int ADDR_W   = 12;
  localparam int DATA_W   = 32;
  localparam int ID_BYTES = 4;
  localparam int ID_IDX_W = $clog2(ID_BYTES);

  typedef enum logic [1:0] {RD_NONE, RD_DATA, RD_DIR, RD_ID} rdSel_e;

  typedef struct packed {
    logic                  dataWr;
    logic                  dirWr;
    rdSel_e                rdSel;
    logic [ID_IDX_W-1:0]   idIdx;
    logic [NUM_PINS-1:0]   mask;
  } strobes_t;
endpackage

// File: rtl/gpioCtrl.sv
module gpioCtrl
  import gpio_pkg::*;
#(
  parameter int DIR_OFFSET = 'h400,
  parameter int ID_OFFSET  = 'hFE0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  output strobes_t          strb
);
  localparam int WORD_W   = ADDR_W - 2;
  localparam int DIR_WORD = DIR_OFFSET / 4;
  localparam int ID_WORD  = ID_OFFSET / 4;
  // data window spans NUM_PINS mask bits above the byte lane bits
  localparam int WIN_TOP  = NUM_PINS + 2;

  logic [WORD_W-1:0] wordAddr;
  logic inData, inDir, inId, accessWr;

  assign wordAddr = paddr[ADDR_W-1:2];
  assign inData   = (paddr[ADDR_W-1:WIN_TOP] == '0);
  assign inDir    = (int'(wordAddr) == DIR_WORD);
  assign inId     = (int'(wordAddr) >= ID_WORD) && (int'(wordAddr) < ID_WORD + ID_BYTES);
  assign accessWr = psel && penable && pwrite;

  always_comb begin
    strb        = '0;
    strb.mask   = paddr[WIN_TOP-1:2];
    strb.idIdx  = wordAddr[ID_IDX_W-1:0];
    strb.dataWr = accessWr && inData;
    strb.dirWr  = accessWr && inDir;
    strb.rdSel  = RD_NONE;
    if (psel && !pwrite) begin
      if (inData)      strb.rdSel = RD_DATA;
      else if (inDir)  strb.rdSel = RD_DIR;
      else if (inId)   strb.rdSel = RD_ID;
    end
  end

  // R9: at most one register takes a write per cycle
  p_one_write_r9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.dataWr, strb.dirWr}));
endmodule

// File: rtl/gpioDatapath.sv
module gpioDatapath
  import gpio_pkg::*;
#(
  parameter logic [DATA_W-1:0] ID_VALUE = 32'h0004_1061
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobes_t            strb,
  input  logic [DATA_W-1:0]   pwdata,
  input  logic [NUM_PINS-1:0] padIn,
  output logic [DATA_W-1:0]   prdata,
  output logic [NUM_PINS-1:0] padOut,
  output logic [NUM_PINS-1:0] padOe,
  output logic [NUM_PINS-1:0] syncIn
);
  logic [NUM_PINS-1:0] outReg, dirReg, syncMeta, syncReg, pinView;
  logic [7:0]          idBytes [ID_BYTES];
  logic [1:0]          upCnt;

  genvar gi;
  generate
    for (gi = 0; gi < ID_BYTES; gi++) begin : g_id
      assign idBytes[gi] = ID_VALUE[8*gi +: 8];
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outReg   <= '0;
      dirReg   <= '0;
      syncMeta <= '0;
      syncReg  <= '0;
    end else begin
      syncMeta <= padIn;
      syncReg  <= syncMeta;
      if (strb.dirWr) dirReg <= pwdata[NUM_PINS-1:0];
      if (strb.dataWr)
        outReg <= (outReg & ~strb.mask) | (pwdata[NUM_PINS-1:0] & strb.mask);
    end
  end

  assign pinView = (dirReg & outReg) | (~dirReg & syncReg);

  always_comb begin
    prdata = '0;
    unique case (strb.rdSel)
      RD_DATA: prdata[NUM_PINS-1:0] = pinView & strb.mask;
      RD_DIR:  prdata[NUM_PINS-1:0] = dirReg;
      RD_ID:   prdata[7:0]          = idBytes[strb.idIdx];
      default: prdata = '0;
    endcase
  end

  assign padOut = outReg;
  assign padOe  = dirReg;
  assign syncIn = syncReg;

  // cycles since reset, saturating, used only by the latency check
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             upCnt <= '0;
    else if (upCnt != 2'd2) upCnt <= upCnt + 2'd1;
  end

  p_keep_unmasked_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.dataWr |=> ((outReg ^ $past(outReg)) & ~$past(strb.mask)) == '0);

  p_masked_zero_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdSel == RD_DATA) |-> ((prdata[NUM_PINS-1:0] & ~strb.mask) == '0));

  p_sync_latency_r5: assert property (@(posedge clk) disable iff (!rstN)
    (upCnt == 2'd2) |-> (syncIn == $past(padIn, 2)));

  p_dir_write_r6: assert property (@(posedge clk) disable iff (!rstN)
    strb.dirWr |=> (padOe == $past(pwdata[NUM_PINS-1:0])));

  p_regs_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.dirWr || strb.dataWr) |=> ($stable(padOe) && $stable(padOut)));
endmodule

// File: rtl/gpioMaskedPort.sv
module gpioMaskedPort
  import gpio_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                psel,
  input  logic                penable,
  input  logic                pwrite,
  input  logic [ADDR_W-1:0]   paddr,
  input  logic [DATA_W-1:0]   pwdata,
  output logic [DATA_W-1:0]   prdata,
  input  logic [NUM_PINS-1:0] padIn,
  output logic [NUM_PINS-1:0] padOut,
  output logic [NUM_PINS-1:0] padOe,
  output logic [NUM_PINS-1:0] syncIn
);
  strobes_t strb;

  gpioCtrl i_ctrl (
    .clk(clk), .rstN(rstN), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .strb(strb)
  );

  gpioDatapath i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .pwdata(pwdata), .padIn(padIn),
    .prdata(prdata), .padOut(padOut), .padOe(padOe), .syncIn(syncIn)
  );
endmodule

// File: tb/test_gpioMaskedPort.sv
module test_gpioMaskedPort;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 5000;

  logic        clk = 0, rstN = 0;
  logic        psel = 0, penable = 0, pwrite = 0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic [7:0]  padIn = '0, padOut, padOe, syncIn;

  int checks = 0, errors = 0;
  bit done = 0;

  typedef struct { logic [31:0] exp; string tag; } item_t;
  item_t sbq[$];

  logic [7:0] mOut = '0, mDir = '0;

  gpioMaskedPort i_gpioMaskedPort (
    .clk(clk), .rstN(rstN), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .padIn(padIn),
    .padOut(padOut), .padOe(padOe), .syncIn(syncIn)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [11:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
    @(posedge clk); #1; penable = 1;
    @(posedge clk); #1; psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic busRead(input logic [11:0] a, input logic [31:0] exp, input string tag);
    item_t it;
    it.exp = exp; it.tag = tag;
    sbq.push_back(it);
    @(posedge clk); #1;
    psel = 1; penable = 0; pwrite = 0; paddr = a;
    @(posedge clk); #1; penable = 1;
    @(posedge clk); #1; psel = 0; penable = 0;
  endtask

  function automatic logic [7:0] pinModel(input logic [7:0] m);
    return ((mDir & mOut) | (~mDir & padIn)) & m;
  endfunction

  // monitor: compare every read in its access phase
  always @(negedge clk) begin
    if (psel && penable && !pwrite) begin
      if (sbq.size() == 0) begin
        checks++; errors++;
        $display("FAIL scoreboard: actual 0x%0h expected none", prdata);
      end else begin
        item_t it;
        it = sbq.pop_front();
        check(it.tag, prdata, it.exp);
      end
    end
  end

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    for (int i = 0; i < WATCHDOG; i++) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check("R1 padOe", {24'h0, padOe}, 32'h0);
    check("R1 padOut", {24'h0, padOut}, 32'h0);
    rstN = 1;
    busRead(12'h400, 32'h0, "R1 dir");

    // R6 direction register
    busWrite(12'h400, 32'hFF); mDir = 8'hFF;
    #2 check("R6 padOe", {24'h0, padOe}, 32'hFF);
    busRead(12'h400, 32'hFF, "R6 dir read");

    // R2 full-mask then single-pin write
    busWrite(12'h3FC, 32'hA5); mOut = 8'hA5;
    check("R2 full write", {24'h0, padOut}, 32'hA5);
    busWrite(12'h004, 32'h00); mOut = 8'hA4;
    check("R2 pin0 clear", {24'h0, padOut}, 32'hA4);
    busWrite(12'h040, 32'hFF); mOut = 8'hB4;
    check("R2 pin4 set", {24'h0, padOut}, 32'hB4);

    // R10 zero mask
    busWrite(12'h000, 32'hFF);
    check("R10 no change", {24'h0, padOut}, {24'h0, mOut});

    // R3 masked reads
    busRead(12'h3FC, {24'h0, mOut}, "R3 full read");
    busRead(12'h0C0, {24'h0, mOut & 8'h30}, "R3 mask 0x30");
    busRead(12'h008, {24'h0, mOut & 8'h02}, "R3 mask pin1");

    // R4 mixed direction; direction change then read next transfer
    padIn = 8'h3C;
    busWrite(12'h400, 32'h0F); mDir = 8'h0F;
    busRead(12'h3FC, {24'h0, pinModel(8'hFF)}, "R4 mixed read");
    busRead(12'h3C0, {24'h0, pinModel(8'hF0)}, "R4 input half");

    // R5 synchronizer latency
    @(posedge clk); #1 padIn = 8'hC3;
    @(posedge clk); #1 check("R5 one edge", {24'h0, syncIn}, 32'h3C);
    @(posedge clk); #1 check("R5 two edges", {24'h0, syncIn}, 32'hC3);

    // R7 write to input-configured pins still updates padOut
    busWrite(12'h400, 32'h00); mDir = 8'h00;
    busWrite(12'h3FC, 32'h5A); mOut = 8'h5A;
    check("R7 padOut", {24'h0, padOut}, 32'h5A);
    check("R7 padOe", {24'h0, padOe}, 32'h00);
    busRead(12'h3FC, {24'h0, pinModel(8'hFF)}, "R7 reads pads");

    // R8 identification bytes
    busRead(12'hFE0, 32'h61, "R8 id0");
    busRead(12'hFE4, 32'h10, "R8 id1");
    busRead(12'hFE8, 32'h04, "R8 id2");
    busRead(12'hFEC, 32'h00, "R8 id3");

    // R9 unmapped offsets
    busWrite(12'h400, 32'h0F); mDir = 8'h0F;
    busRead(12'h404, 32'h0, "R9 read 0x404");
    busRead(12'h800, 32'h0, "R9 read 0x800");
    busWrite(12'h800, 32'hFF);
    busWrite(12'h404, 32'hFF);
    check("R9 padOut", {24'h0, padOut}, 32'h5A);
    check("R9 padOe", {24'h0, padOe}, 32'h0F);
    busRead(12'h400, 32'h0F, "R9 dir kept");

    @(posedge clk); @(posedge clk);
    if (sbq.size() != 0) begin
      checks++; errors++;
      $display("FAIL scoreboard: actual %0d pending expected 0", sbq.size());
    end
    finishRun();
  end
endmodule